// File: doc/BRIEF.md
# Dual-Mode Host Read Data Path

This block moves 24-bit words from a processor core towards an external host and reports two flags: one telling the core it may write, and one telling the host that a word is waiting. It has two operating modes. In prefetch mode the path works as a bounded queue. Its total capacity is six words, or three words when the wide (32-bit) host data format is selected. In fetch mode nothing is buffered. A single word is produced only while a host read transfer is in progress. If that transfer ends, the path empties itself and any word still in it is lost.

Inside, the path has two stages. The core-side stage is a small circular store. The host-side stage is one output register, and a word moves into it one cycle after it is written whenever that register is empty. A state machine selects the mode. Its states are ST_PREFETCH, ST_FETCH_IDLE, ST_FETCH_OPEN and ST_FETCH_FULL, and its transitions are:
- *enter_fetch*: ST_PREFETCH to ST_FETCH_IDLE, on an accepted fetch request.
- *leave_fetch*: ST_FETCH_IDLE or ST_FETCH_OPEN to ST_PREFETCH, on an accepted prefetch request.
- *open*: ST_FETCH_IDLE to ST_FETCH_OPEN, when the host read is active.
- *fill*: ST_FETCH_OPEN to ST_FETCH_FULL, on an accepted core write.
- *drain*: ST_FETCH_FULL to ST_FETCH_OPEN, on a host pop.
- *abort*: ST_FETCH_OPEN or ST_FETCH_FULL to ST_FETCH_IDLE, when the host read goes inactive.

A mode request is honoured only while both stages are empty. A refused request leaves the mode unchanged and sets a sticky error flag.

Top module: `hrd_path`

## Requirements
- R1: After reset the block is in prefetch mode. In that state core_may_write=1, host_data_ready=0, host_data=0, fetch_mode=0 and mode_err=0.
- R2: In prefetch mode with fmt_wide=0, the path accepts exactly six core writes before core_may_write drops, provided no host read takes place.
- R3: In prefetch mode with fmt_wide=1, the path accepts exactly three core writes before core_may_write drops.
- R4: Words reach the host in the order they were written. A word written at clock edge k into an empty path raises host_data_ready after edge k+1.
- R5: host_data_ready is 1 exactly when the host-side stage holds a word. While it is 0, host_data reads 0, and a host_rd pulse changes nothing.
- R6: A core write made while core_may_write is 0 is dropped and never reaches the host.
- R7: After an accepted fetch request, fetch_mode=1 and both flags are 0 (state ST_FETCH_IDLE).
- R8: In fetch mode, core_may_write rises one edge after host_rd_active is seen high. It falls after one accepted core write, and that word becomes ready one edge later. After the host pops it, core_may_write rises again while host_rd_active stays high.
- R9: In fetch mode, a cycle with host_rd_active=0 empties both stages. After the edge both flags are 0, and the discarded word never appears.
- R10: A mode request (mode_req=1, mode_sel_fetch selecting fetch=1 or prefetch=0) is accepted only when both stages are empty. Otherwise the mode is kept and mode_err is set and stays set. A core write in the same cycle as an accepted request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_wide | input | 1 | 1 selects the 32-bit host format (three-word prefetch capacity) |
| mode_req | input | 1 | One-cycle mode change request |
| mode_sel_fetch | input | 1 | Requested mode: 1 fetch, 0 prefetch |
| core_wr | input | 1 | Core write strobe |
| core_data | input | 24 | Core write word |
| host_rd_active | input | 1 | Host read transfer in progress (used in fetch mode) |
| host_rd | input | 1 | Host pops the ready word |
| host_data | output | 24 | Ready word, zero when none |
| core_may_write | output | 1 | Core may write this cycle |
| host_data_ready | output | 1 | A word waits for the host |
| fetch_mode | output | 1 | 1 while in fetch mode |
| mode_err | output | 1 | Sticky: a mode request was refused |

## Verification
The assertions assume that fmt_wide only changes while the path is empty. They also assume that host_rd_active is held steady across a fetch exchange, apart from the deliberate abort. The stimulus sets the format only just after reset or after a full drain. It drives every input shortly after a rising edge, so requests, writes and pops each last one whole cycle. Mode requests are raised in cycles where the bench knows the fill state, so both the accepted case and the refused case are covered on purpose.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
    typedef enum logic [1:0] {
        ST_PREFETCH   = 2'd0,
        ST_FETCH_IDLE = 2'd1,
        ST_FETCH_OPEN = 2'd2,
        ST_FETCH_FULL = 2'd3
    } hrd_state_e;
endpackage

// File: rtl/hrd_fifo.sv
module hrd_fifo #(
    parameter int W     = 24,
    parameter int NMAX  = 6,
    parameter int NWIDE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         fmt_wide,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         fifo_empty,
    output logic         not_full,
    output logic         hrx_valid,
    output logic [W-1:0] hrx_data
);
    localparam int SLOTS = NMAX - 1;
    localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CW    = $clog2(SLOTS + 1);

    logic [W-1:0]  mem [SLOTS];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt, lim;
    logic          move;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
    endfunction

    assign lim        = fmt_wide ? CW'(NWIDE - 1) : CW'(SLOTS);
    assign not_full   = cnt < lim;
    assign fifo_empty = (cnt == '0);
    assign move       = !fifo_empty && !hrx_valid;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            cnt       <= '0;
            hrx_valid <= 1'b0;
            hrx_data  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wrap_inc(wr_ptr);
            end
            if (move) begin
                rd_ptr    <= wrap_inc(rd_ptr);
                hrx_data  <= mem[rd_ptr];
                hrx_valid <= 1'b1;
            end else if (pop) begin
                hrx_valid <= 1'b0;
            end
            cnt <= cnt + CW'(push) - CW'(move);
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < lim));

    // R5
    pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !hrx_valid);
endmodule

// File: rtl/hrd_mode_ctl.sv
module hrd_mode_ctl
    import hrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_req,
    input  logic       mode_sel_fetch,
    input  logic       host_rd_active,
    input  logic       push,
    input  logic       pop,
    input  logic       path_empty,
    output hrd_state_e state,
    output logic       flush,
    output logic       mode_acc,
    output logic       mode_err
);
    hrd_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_PREFETCH;
            mode_err <= 1'b0;
        end else begin
            state <= nxt;
            if (mode_req && !path_empty) begin
                mode_err <= 1'b1;
            end
        end
    end

    always_comb begin
        mode_acc = mode_req && path_empty;
        flush    = 1'b0;
        nxt      = state;
        unique case (state)
            ST_PREFETCH: begin
                if (mode_acc && mode_sel_fetch) nxt = ST_FETCH_IDLE;
            end
            ST_FETCH_IDLE: begin
                if (mode_acc && !mode_sel_fetch) nxt = ST_PREFETCH;
                else if (host_rd_active)         nxt = ST_FETCH_OPEN;
            end
            ST_FETCH_OPEN: begin
                if (!host_rd_active) begin
                    flush = 1'b1;
                    nxt   = ST_FETCH_IDLE;
                end else if (mode_acc && !mode_sel_fetch) begin
                    nxt = ST_PREFETCH;
                end else if (push) begin
                    nxt = ST_FETCH_FULL;
                end
            end
            ST_FETCH_FULL: begin
                if (!host_rd_active) begin
                    flush = 1'b1;
                    nxt   = ST_FETCH_IDLE;
                end else if (pop) begin
                    nxt = ST_FETCH_OPEN;
                end
            end
        endcase
    end

    // R9
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FETCH_OPEN || state == ST_FETCH_FULL) && !host_rd_active)
        |=> (state == ST_FETCH_IDLE));

    // R10
    reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && !path_empty) |=> mode_err);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && !path_empty && state == ST_PREFETCH) |=> (state == ST_PREFETCH));
endmodule

// File: rtl/hrd_path.sv
module hrd_path
    import hrd_pkg::*;
#(
    parameter int W     = 24,
    parameter int NMAX  = 6,
    parameter int NWIDE = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fmt_wide,
    input  logic         mode_req,
    input  logic         mode_sel_fetch,
    input  logic         core_wr,
    input  logic [W-1:0] core_data,
    input  logic         host_rd_active,
    input  logic         host_rd,
    output logic [W-1:0] host_data,
    output logic         core_may_write,
    output logic         host_data_ready,
    output logic         fetch_mode,
    output logic         mode_err
);
    hrd_state_e   state;
    logic         flush, mode_acc, push, pop;
    logic         fifo_empty, not_full, hrx_valid, path_empty;
    logic [W-1:0] hrx_data;

    always_comb begin
        unique case (state)
            ST_PREFETCH:   core_may_write = not_full;
            ST_FETCH_OPEN: core_may_write = host_rd_active;
            default:       core_may_write = 1'b0;
        endcase
        push            = core_wr && core_may_write && !mode_acc;
        pop             = host_rd && hrx_valid && !flush;
        path_empty      = fifo_empty && !hrx_valid;
        host_data_ready = hrx_valid;
        host_data       = hrx_valid ? hrx_data : '0;
        fetch_mode      = (state != ST_PREFETCH);
    end

    hrd_mode_ctl i_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_req       (mode_req),
        .mode_sel_fetch (mode_sel_fetch),
        .host_rd_active (host_rd_active),
        .push           (push),
        .pop            (pop),
        .path_empty     (path_empty),
        .state          (state),
        .flush          (flush),
        .mode_acc       (mode_acc),
        .mode_err       (mode_err)
    );

    hrd_fifo #(.W(W), .NMAX(NMAX), .NWIDE(NWIDE)) i_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fmt_wide   (fmt_wide),
        .push       (push),
        .push_data  (core_data),
        .pop        (pop),
        .fifo_empty (fifo_empty),
        .not_full   (not_full),
        .hrx_valid  (hrx_valid),
        .hrx_data   (hrx_data)
    );

    // R7
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_IDLE) |-> (!core_may_write && !host_data_ready));

    // R8
    full_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_FULL) |-> (hrx_valid || !fifo_empty));

    // R5
    zero_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_data_ready |-> (host_data == '0));
endmodule

// File: tb/test_hrd_path.sv
`timescale 1ns/1ps
module test_hrd_path;
    logic        clk = 1'b0;
    logic        rst_n, fmt_wide, mode_req, mode_sel_fetch, core_wr, host_rd_active, host_rd;
    logic [23:0] core_data, host_data;
    logic        core_may_write, host_data_ready, fetch_mode, mode_err;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    hrd_path i_hrd_path (
        .clk(clk), .rst_n(rst_n), .fmt_wide(fmt_wide), .mode_req(mode_req),
        .mode_sel_fetch(mode_sel_fetch), .core_wr(core_wr), .core_data(core_data),
        .host_rd_active(host_rd_active), .host_rd(host_rd), .host_data(host_data),
        .core_may_write(core_may_write), .host_data_ready(host_data_ready),
        .fetch_mode(fetch_mode), .mode_err(mode_err)
    );

    // fields: wr, data[24], rd, exp_cmw, exp_hdr, exp_data[24]
    localparam int NV = 8;
    localparam logic [51:0] VEC [NV] = '{
        {1'b1, 24'h00A001, 1'b0, 1'b1, 1'b0, 24'h000000},
        {1'b0, 24'h000000, 1'b0, 1'b1, 1'b1, 24'h00A001},
        {1'b1, 24'h00B002, 1'b0, 1'b1, 1'b1, 24'h00A001},
        {1'b0, 24'h000000, 1'b1, 1'b1, 1'b0, 24'h000000},
        {1'b0, 24'h000000, 1'b0, 1'b1, 1'b1, 24'h00B002},
        {1'b1, 24'h00C003, 1'b1, 1'b1, 1'b0, 24'h000000},
        {1'b0, 24'h000000, 1'b1, 1'b1, 1'b1, 24'h00C003},
        {1'b0, 24'h000000, 1'b1, 1'b1, 1'b0, 24'h000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        core_wr = 1'b0; host_rd = 1'b0; mode_req = 1'b0;
    endtask

    // fill without reading; return accepted count and stored words
    task automatic fill(output int acc, output logic [23:0] got [8]);
        acc = 0;
        for (int i = 0; i < 10; i++) begin
            core_wr   = 1'b1;
            core_data = 24'h100 + 24'(i);
            if (core_may_write) begin
                got[acc] = core_data;
                acc++;
            end
            step();
        end
        idle_in();
        step();
    endtask

    task automatic drain(input string req, input int acc, input logic [23:0] got [8]);
        int n = 0;
        for (int i = 0; i < 10; i++) begin
            if (host_data_ready) begin
                if (n < 8) chk(req, 32'(host_data), 32'(got[n]));
                n++;
                host_rd = 1'b1;
                step();
                host_rd = 1'b0;
                step();
            end
        end
        chk(req, 32'(n), 32'(acc));
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int          acc;
        logic [23:0] got [8];
        rst_n = 1'b0; fmt_wide = 1'b0; mode_sel_fetch = 1'b0; host_rd_active = 1'b0;
        core_data = '0;
        idle_in();
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 cmw", 32'(core_may_write), 32'd1);
        chk("R1 hdr", 32'(host_data_ready), 32'd0);
        chk("R1 data", 32'(host_data), 32'd0);
        chk("R1 mode", 32'(fetch_mode), 32'd0);
        chk("R1 err", 32'(mode_err), 32'd0);

        // R4 R5 vector walk in prefetch mode
        for (int v = 0; v < NV; v++) begin
            core_wr   = VEC[v][51];
            core_data = VEC[v][50:27];
            host_rd   = VEC[v][26];
            step();
            chk("R4 cmw", 32'(core_may_write), 32'(VEC[v][25]));
            chk("R5 hdr", 32'(host_data_ready), 32'(VEC[v][24]));
            chk("R4 data", 32'(host_data), 32'(VEC[v][23:0]));
        end
        idle_in();
        step();

        // R2 six-word capacity, R6 extra writes dropped
        fill(acc, got);
        chk("R2 accepted", 32'(acc), 32'd6);
        chk("R6 cmw low when full", 32'(core_may_write), 32'd0);
        drain("R6 order and count", acc, got);
        chk("R6 empty after drain", 32'(host_data_ready), 32'd0);

        // R3 three-word capacity in wide format
        fmt_wide = 1'b1;
        step();
        fill(acc, got);
        chk("R3 accepted", 32'(acc), 32'd3);
        drain("R3 order", acc, got);
        fmt_wide = 1'b0;
        step();

        // R10 rejected request while path holds data
        core_wr = 1'b1; core_data = 24'h0000D1;
        step();
        idle_in();
        step();
        mode_req = 1'b1; mode_sel_fetch = 1'b1;
        step();
        idle_in();
        chk("R10 mode kept", 32'(fetch_mode), 32'd0);
        chk("R10 err set", 32'(mode_err), 32'd1);
        chk("R10 word kept", 32'(host_data), 32'h0000D1);
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        step();

        // R10 accepted request, R7 fetch entry; simultaneous write dropped
        mode_req = 1'b1; mode_sel_fetch = 1'b1; core_wr = 1'b1; core_data = 24'h0000EE;
        step();
        idle_in();
        chk("R7 fetch mode", 32'(fetch_mode), 32'd1);
        chk("R7 cmw clear", 32'(core_may_write), 32'd0);
        chk("R7 hdr clear", 32'(host_data_ready), 32'd0);
        step();
        chk("R10 write dropped", 32'(host_data_ready), 32'd0);
        chk("R10 err sticky", 32'(mode_err), 32'd1);

        // R8 fetch exchange
        host_rd_active = 1'b1;
        step();
        chk("R8 cmw open", 32'(core_may_write), 32'd1);
        chk("R5 not ready", 32'(host_data_ready), 32'd0);
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        chk("R5 read when empty", 32'(host_data), 32'd0);
        chk("R5 cmw unchanged", 32'(core_may_write), 32'd1);
        core_wr = 1'b1; core_data = 24'h0000F1;
        step();
        core_wr = 1'b0;
        chk("R8 cmw after write", 32'(core_may_write), 32'd0);
        chk("R8 not yet ready", 32'(host_data_ready), 32'd0);
        step();
        chk("R8 ready", 32'(host_data_ready), 32'd1);
        chk("R8 data", 32'(host_data), 32'h0000F1);
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        chk("R8 reopen", 32'(core_may_write), 32'd1);
        chk("R8 popped", 32'(host_data_ready), 32'd0);

        // R9 abort discards word
        core_wr = 1'b1; core_data = 24'h0000F2;
        step();
        core_wr = 1'b0;
        step();
        chk("R9 word ready", 32'(host_data_ready), 32'd1);
        host_rd_active = 1'b0;
        step();
        chk("R9 hdr cleared", 32'(host_data_ready), 32'd0);
        chk("R9 cmw cleared", 32'(core_may_write), 32'd0);
        host_rd_active = 1'b1;
        step();
        chk("R9 reopen", 32'(core_may_write), 32'd1);
        chk("R9 word lost", 32'(host_data_ready), 32'd0);
        step();
        chk("R9 still lost", 32'(host_data), 32'd0);

        // R10 back to prefetch from an empty open path
        mode_req = 1'b1; mode_sel_fetch = 1'b0;
        step();
        idle_in();
        host_rd_active = 1'b0;
        chk("R10 prefetch again", 32'(fetch_mode), 32'd0);
        chk("R10 cmw prefetch", 32'(core_may_write), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule